// File: doc/BRIEF.md
# Flash Self-Programming Page Buffer Controller

This block sits between a CPU and a small on-chip flash array and lets the CPU reprogram that flash itself. The CPU first writes a command into an 8-bit control register, which arms the command. It then raises a program strobe with a word address and a 16-bit data word. The block accepts four commands. A fill stores a word into a temporary page buffer. An erase sets a whole page to ones. A write programs the buffer contents into a page. A read re-enable makes the flash region readable again after programming.

The temporary buffer follows strict rules. Each entry can be written only once between clears, and a second fill ANDs the new data into the entry. The buffer is flushed when a page write completes, on reset, and when the read re-enable command runs. An erase leaves the buffer untouched. Because of this, a sequence of fill, then erase, then write only gives the filled data if no re-enable is issued between the erase and the write. While an erase or write runs, the busy flag and a region-busy flag are set and flash reads are blocked. The region stays blocked until software issues the re-enable command. The flash array is a behavioural memory with fixed erase and write latencies.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `busy`, `rww_busy` and `rd_blocked` are low, and every buffer entry holds 0xFFFF.
- R2: Control values select the commands: 0x01 fill, 0x03 erase, 0x05 write and 0x11 read re-enable (bit 0 is the enable bit, bit 4 the re-enable bit). Any other value disarms and does nothing.
- R3: An armed command runs only if `spm_stb` is sampled high on one of the 1st to 4th rising edges after the control write. Otherwise the command is dropped after the 4th edge and `busy` returns low.
- R4: The low 5 bits of the word address (bits 4:0) select one of 32 buffer entries or page words. The upper 3 bits (bits 7:5) select the page.
- R5: A fill ANDs its data into the selected entry. The first fill after a clear therefore stores the data, and a repeated fill leaves the AND of both values.
- R6: The buffer is cleared to all ones when a page write completes, on reset, and when the read re-enable command runs.
- R7: An erase does not clear the buffer. Filling, then erasing, then writing the same page puts the filled data into flash.
- R8: An erase sets all 32 words of the page to 0xFFFF. `busy` is high for exactly ERASE_CYC sampled cycles starting with the strobe edge.
- R9: A write stores each page word ANDed with its buffer entry. `busy` is high for exactly WRITE_CYC sampled cycles.
- R10: While an erase or write runs, `busy` and `rww_busy` are high. `rww_busy` stays high until a re-enable. While it is high, `rd_blocked` is 1 and `rd_data` reads 0.
- R11: Control writes made while an erase or write is running are ignored, including a re-enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| spm_stb | input | 1 | Program strobe that executes the armed command |
| spm_waddr | input | 8 | Word address: page in bits 7:5, word in bits 4:0 |
| spm_data | input | 16 | Data word for a fill |
| rd_waddr | input | 8 | Flash read word address |
| rd_data | output | 16 | Flash read data, 0 while blocked |
| rd_blocked | output | 1 | Region read blocked |
| busy | output | 1 | Command armed or erase/write running |
| rww_busy | output | 1 | Region busy since the last erase/write, until re-enabled |

## Verification
The bench compares the late-erase order (fill, erase, write) with the normal order. A design that flushed the buffer on erase would leave 0xFFFF where the pattern belongs. It also issues a re-enable between erase and write and expects the filled data to be lost, which catches a re-enable that forgets to flush. Double fills and writes over unerased data expose a buffer or array that replaces instead of ANDs. Strobes on the 4th and 5th cycle after arming check the window edge in both directions. Commands issued during a write, including a re-enable, must leave the buffer and the region flag unchanged.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  localparam int DATA_W = 16;

  localparam logic [7:0] CTL_FILL  = 8'h01;
  localparam logic [7:0] CTL_ERASE = 8'h03;
  localparam logic [7:0] CTL_WRITE = 8'h05;
  localparam logic [7:0] CTL_REEN  = 8'h11;

  typedef enum logic [2:0] {OP_NONE, OP_FILL, OP_ERASE, OP_WRITE, OP_REEN} op_e;

  function automatic op_e decode_ctl(input logic [7:0] v);
    case (v)
      CTL_FILL:  return OP_FILL;
      CTL_ERASE: return OP_ERASE;
      CTL_WRITE: return OP_WRITE;
      CTL_REEN:  return OP_REEN;
      default:   return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/selfprog_cmd.sv
module selfprog_cmd
  import selfprog_pkg::*;
#(
  parameter int ARM_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       spm_stb,
  input  logic       op_run,
  output logic       armed,
  output logic       go_fill,
  output logic       go_erase,
  output logic       go_write,
  output logic       go_reen
);
  localparam int CNT_W = $clog2(ARM_WIN + 1);

  op_e              op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             accept, fire;

  assign accept = ctl_we & ~op_run;
  assign fire   = armed_q & spm_stb & ~accept;

  always_comb begin
    op_d    = op_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (accept) begin
      op_d    = decode_ctl(ctl_wdata);
      armed_d = (op_d != OP_NONE);
      cnt_d   = CNT_W'(ARM_WIN);
    end else if (armed_q) begin
      if (spm_stb || cnt_q == CNT_W'(1)) begin
        armed_d = 1'b0;
        op_d    = OP_NONE;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed    = armed_q;
  assign go_fill  = fire & (op_q == OP_FILL);
  assign go_erase = fire & (op_q == OP_ERASE);
  assign go_write = fire & (op_q == OP_WRITE);
  assign go_reen  = fire & (op_q == OP_REEN);
endmodule

// File: rtl/selfprog_pgbuf.sv
module selfprog_pgbuf #(
  parameter int PAGE_WORDS = 32,
  parameter int DATA_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fill_en,
  input  logic [$clog2(PAGE_WORDS)-1:0] fill_idx,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic                         clr,
  output logic [PAGE_WORDS*DATA_W-1:0] buf_flat
);
  localparam int IDX_W = $clog2(PAGE_WORDS);

  for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q, ent_d;
    logic              ent_en;

    assign ent_en = clr | (fill_en & (fill_idx == IDX_W'(g)));

    always_comb begin
      if (clr) ent_d = '1;
      else     ent_d = ent_q & fill_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '1;
      else if (ent_en) ent_q <= ent_d;
    end

    assign buf_flat[g*DATA_W +: DATA_W] = ent_q;
  end
endmodule

// File: rtl/selfprog_array.sv
module selfprog_array #(
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 8,
  parameter int ERASE_CYC  = 24,
  parameter int WRITE_CYC  = 16,
  parameter int DATA_W     = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     go_erase,
  input  logic                                     go_write,
  input  logic                                     go_reen,
  input  logic [$clog2(NUM_PAGES)-1:0]             page_sel,
  input  logic [PAGE_WORDS*DATA_W-1:0]             buf_flat,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]  rd_word,
  output logic                                     op_run,
  output logic                                     rww_busy,
  output logic                                     wr_done,
  output logic [DATA_W-1:0]                        rd_data
);
  localparam int IDX_W   = $clog2(PAGE_WORDS);
  localparam int PG_W    = $clog2(NUM_PAGES);
  localparam int LAT_MAX = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);
  localparam int DEPTH   = NUM_PAGES * PAGE_WORDS;

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_WRITE} st_e;

  st_e              st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic             rww_q, rww_d;
  logic             done;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    page_d = page_q;
    rww_d  = rww_q;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (go_erase) begin
          st_d   = ST_ERASE;
          cnt_d  = LAT_W'(ERASE_CYC);
          page_d = page_sel;
          rww_d  = 1'b1;
        end else if (go_write) begin
          st_d   = ST_WRITE;
          cnt_d  = LAT_W'(WRITE_CYC);
          page_d = page_sel;
          rww_d  = 1'b1;
        end else if (go_reen) begin
          rww_d = 1'b0;
        end
      end
      default: begin
        if (cnt_q == LAT_W'(1)) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end else begin
          cnt_d = cnt_q - LAT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      page_q <= '0;
      rww_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      page_q <= page_d;
      rww_q  <= rww_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      for (int w = 0; w < PAGE_WORDS; w++) begin
        if (st_q == ST_ERASE)
          mem_q[{page_q, IDX_W'(w)}] <= '1;
        else
          mem_q[{page_q, IDX_W'(w)}] <= mem_q[{page_q, IDX_W'(w)}] & buf_flat[w*DATA_W +: DATA_W];
      end
    end
  end

  assign op_run   = (st_q != ST_IDLE);
  assign rww_busy = rww_q;
  assign wr_done  = done & (st_q == ST_WRITE);
  assign rd_data  = mem_q[rd_word];
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 8,
  parameter int ERASE_CYC  = 24,
  parameter int WRITE_CYC  = 16,
  parameter int ARM_WIN    = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        ctl_we,
  input  logic [7:0]                                  ctl_wdata,
  input  logic                                        spm_stb,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     spm_waddr,
  input  logic [15:0]                                 spm_data,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0]     rd_waddr,
  output logic [15:0]                                 rd_data,
  output logic                                        rd_blocked,
  output logic                                        busy,
  output logic                                        rww_busy
);
  localparam int IDX_W  = $clog2(PAGE_WORDS);
  localparam int ADDR_W = $clog2(NUM_PAGES * PAGE_WORDS);

  logic rst_meta_q, rst_sync_q;
  logic armed, go_fill, go_erase, go_write, go_reen;
  logic op_run, wr_done, buf_clr;
  logic [PAGE_WORDS*DATA_W-1:0] buf_flat;
  logic [DATA_W-1:0] arr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  selfprog_cmd #(.ARM_WIN(ARM_WIN)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .spm_stb  (spm_stb),
    .op_run   (op_run),
    .armed    (armed),
    .go_fill  (go_fill),
    .go_erase (go_erase),
    .go_write (go_write),
    .go_reen  (go_reen)
  );

  assign buf_clr = wr_done | go_reen;

  selfprog_pgbuf #(.PAGE_WORDS(PAGE_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .fill_en  (go_fill),
    .fill_idx (spm_waddr[IDX_W-1:0]),
    .fill_data(spm_data),
    .clr      (buf_clr),
    .buf_flat (buf_flat)
  );

  selfprog_array #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .DATA_W(DATA_W)
  ) u_arr (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .go_erase(go_erase),
    .go_write(go_write),
    .go_reen (go_reen),
    .page_sel(spm_waddr[ADDR_W-1:IDX_W]),
    .buf_flat(buf_flat),
    .rd_word (rd_waddr),
    .op_run  (op_run),
    .rww_busy(rww_busy),
    .wr_done (wr_done),
    .rd_data (arr_rd)
  );

  assign busy       = armed | op_run;
  assign rd_blocked = rww_busy;
  assign rd_data    = rww_busy ? '0 : arr_rd;
endmodule

// File: rtl/selfprog_chk.sv
module selfprog_chk #(
  parameter int PAGE_WORDS = 32,
  parameter int ARM_WIN    = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ctl_we,
  input logic                     armed,
  input logic                     op_run,
  input logic                     rww_busy,
  input logic                     go_reen,
  input logic                     buf_clr,
  input logic [PAGE_WORDS*16-1:0] buf_flat
);
  localparam int AGE_W = $clog2(ARM_WIN + 2);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age_q <= '0;
    else if (ctl_we && !op_run) age_q <= '0;
    else if (armed)             age_q <= age_q + AGE_W'(1);
  end

  AST_OP_HOLDS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    op_run |-> rww_busy);  // R10

  AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (age_q < AGE_W'(ARM_WIN)));  // R3

  AST_BUF_AND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_clr |=> ((buf_flat & ~$past(buf_flat)) == '0));  // R5

  AST_CLEAR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> (buf_flat == '1));  // R6

  AST_REEN_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    go_reen |-> !op_run);  // R11

  AST_NO_ARM_DURING_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && ctl_we) |=> !armed);  // R11
endmodule

bind selfprog_ctrl selfprog_chk #(.PAGE_WORDS(PAGE_WORDS), .ARM_WIN(ARM_WIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_q),
  .ctl_we  (ctl_we),
  .armed   (armed),
  .op_run  (op_run),
  .rww_busy(rww_busy),
  .go_reen (go_reen),
  .buf_clr (buf_clr),
  .buf_flat(buf_flat)
);

// File: tb/selfprog_ctrl_tb.sv
`timescale 1ns/1ps
module selfprog_ctrl_tb;
  localparam int EC = 24;
  localparam int WC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic        spm_stb;
  logic [7:0]  spm_waddr;
  logic [15:0] spm_data;
  logic [7:0]  rd_waddr;
  logic [15:0] rd_data;
  logic        rd_blocked, busy, rww_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  selfprog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .spm_stb(spm_stb), .spm_waddr(spm_waddr), .spm_data(spm_data),
    .rd_waddr(rd_waddr), .rd_data(rd_data), .rd_blocked(rd_blocked),
    .busy(busy), .rww_busy(rww_busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] wa(input int page, input int word);
    return {page[2:0], word[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] v, input int dly, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    repeat (dly - 1) @(negedge clk);
    spm_stb = 1'b1; spm_waddr = a; spm_data = d;
    @(negedge clk); spm_stb = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
  endtask

  task automatic do_op(input logic [7:0] v, input int page);
    cmd(v, 1, wa(page, 0), 16'h0);
    wait_idle();
  endtask

  task automatic rd(input int page, input int word, output logic [15:0] d);
    rd_waddr = wa(page, word);
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 busy", {15'b0, busy}, 16'h0);
    chk("R1 rww_busy", {15'b0, rww_busy}, 16'h0);
    chk("R1 rd_blocked", {15'b0, rd_blocked}, 16'h0);
  endtask

  task automatic t_erase();
    int n;
    logic [15:0] d;
    cmd(8'h03, 1, wa(2, 0), 16'h0);
    chk("R10 busy during erase", {15'b0, busy}, 16'h1);
    chk("R10 rww during erase", {15'b0, rww_busy}, 16'h1);
    chk("R10 blocked", {15'b0, rd_blocked}, 16'h1);
    rd(2, 0, d);
    chk("R10 blocked data", d, 16'h0);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R8 erase latency", 16'(n), 16'(EC));
    chk("R10 rww held after erase", {15'b0, rww_busy}, 16'h1);
    do_op(8'h11, 0);
    chk("R2 reen clears rww", {15'b0, rww_busy}, 16'h0);
    rd(2, 0, d);  chk("R8 erased w0", d, 16'hFFFF);
    rd(2, 31, d); chk("R8 erased w31", d, 16'hFFFF);
  endtask

  task automatic t_late_erase();
    int n;
    logic [15:0] d;
    for (int i = 0; i < 32; i++) cmd(8'h01, 1, wa(3, i), 16'hA500 + 16'(i));
    do_op(8'h03, 3);
    cmd(8'h05, 1, wa(3, 0), 16'h0);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R9 write latency", 16'(n), 16'(WC));
    do_op(8'h11, 0);
    for (int i = 0; i < 32; i += 7) begin
      rd(3, i, d);
      chk("R7 fill-erase-write", d, 16'hA500 + 16'(i));
    end
    rd(3, 31, d); chk("R4 last word", d, 16'hA51F);
  endtask

  task automatic t_normal_and_overwrite();
    logic [15:0] d;
    do_op(8'h03, 4);
    cmd(8'h01, 2, wa(4, 9), 16'h1357);
    do_op(8'h05, 4);
    do_op(8'h11, 0);
    rd(4, 9, d);  chk("R4 normal order", d, 16'h1357);
    rd(4, 10, d); chk("R4 untouched word", d, 16'hFFFF);
    cmd(8'h01, 1, wa(3, 0), 16'h0F0F);
    do_op(8'h05, 3);
    do_op(8'h11, 0);
    rd(3, 0, d); chk("R9 write ANDs", d, 16'h0500);
    rd(3, 1, d); chk("R9 others kept", d, 16'hA501);
  endtask

  task automatic t_reen_loses();
    logic [15:0] d;
    cmd(8'h01, 1, wa(5, 4), 16'h4242);
    do_op(8'h03, 5);
    do_op(8'h11, 0);
    do_op(8'h05, 5);
    do_op(8'h11, 0);
    rd(5, 4, d); chk("R6 reen flushes buffer", d, 16'hFFFF);
  endtask

  task automatic t_double_fill();
    logic [15:0] d;
    cmd(8'h01, 1, wa(6, 0), 16'hF0F0);
    cmd(8'h01, 3, wa(6, 0), 16'h3C3C);
    do_op(8'h03, 6);
    do_op(8'h05, 6);
    do_op(8'h11, 0);
    rd(6, 0, d); chk("R5 second fill ANDs", d, 16'h3030);
  endtask

  task automatic t_window();
    logic [15:0] d;
    cmd(8'h01, 4, wa(7, 1), 16'h1234);
    cmd(8'h01, 5, wa(7, 2), 16'h5678);
    chk("R3 dropped clears busy", {15'b0, busy}, 16'h0);
    cmd(8'h21, 1, wa(7, 3), 16'h0000);
    chk("R2 unknown code idle", {15'b0, busy}, 16'h0);
    do_op(8'h03, 7);
    do_op(8'h05, 7);
    do_op(8'h11, 0);
    rd(7, 1, d); chk("R3 4th cycle accepted", d, 16'h1234);
    rd(7, 2, d); chk("R3 5th cycle dropped", d, 16'hFFFF);
    rd(7, 3, d); chk("R2 unknown code no fill", d, 16'hFFFF);
  endtask

  task automatic t_ignored_busy();
    logic [15:0] d;
    do_op(8'h03, 1);
    do_op(8'h11, 0);
    cmd(8'h01, 1, wa(1, 0), 16'h00FF);
    cmd(8'h05, 1, wa(1, 0), 16'h0);
    cmd(8'h01, 1, wa(1, 0), 16'h0000);
    cmd(8'h11, 1, wa(1, 0), 16'h0);
    wait_idle();
    chk("R11 reen ignored during op", {15'b0, rww_busy}, 16'h1);
    do_op(8'h11, 0);
    rd(1, 0, d); chk("R11 fill ignored during op", d, 16'h00FF);
    do_op(8'h03, 1);
    do_op(8'h05, 1);
    do_op(8'h11, 0);
    rd(1, 0, d); chk("R6 write completion flushes", d, 16'hFFFF);
  endtask

  task automatic t_reset_flush();
    logic [15:0] d;
    cmd(8'h01, 1, wa(0, 5), 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    do_op(8'h03, 0);
    do_op(8'h05, 0);
    do_op(8'h11, 0);
    rd(0, 5, d); chk("R6 reset flushes buffer", d, 16'hFFFF);
  endtask

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; spm_stb = 1'b0;
    spm_waddr = '0; spm_data = '0; rd_waddr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_erase();
    t_late_erase();
    t_normal_and_overwrite();
    t_reen_loses();
    t_double_fill();
    t_window();
    t_ignored_busy();
    t_reset_flush();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule